// File: doc/BRIEF.md
# Sense Indicator Register Unit

This block holds a 36-bit sense indicator word and changes it one operation at a time. An operation takes its operand from one of three places: a 36-bit storage word, the accumulator field P..35, or an 18-bit immediate steered onto either the left half (indicators 0..17) or the right half (indicators 18..35). The whole-word operations are load, OR, invert and reset. The half-word operations are set, invert and reset. The block can also hand the indicator contents out, either as a word to be written to storage or as a new accumulator value.

Every change is made through two control lines per bit. The set line turns a bit on and the reset line turns a bit off. When both lines are active together, the bit is complemented. The decoder raises a line for a bit only where the operand bit is one. A load first clears every bit and then sets from the operand, and this happens within one clock. At most one operation is accepted per cycle, and its effect appears after the next rising edge.

A small state machine sequences the output transfers. State `ST_IDLE` drives no transfer. State `ST_ACC_PUSH` presents the indicator word on the accumulator write port. State `ST_STOR_PUSH` presents it on the storage write port. The transitions are checked on every clock edge:
- From any state, an accepted code 14 moves the machine to `ST_ACC_PUSH`.
- From any state, an accepted code 15 moves it to `ST_STOR_PUSH`.
- Any other cycle returns the machine to `ST_IDLE`.

Top module: `sind_reg_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, every indicator reads 0 and both write strobes are 0.
- R2: The set line never turns an indicator off. Code 8 ORs `imm` bit j into indicator j. Code 9 ORs `imm` bit j into indicator 18+j.
- R3: The reset line only turns indicators off. Code 4 clears each indicator whose storage bit is one. Code 12 clears indicator j where `imm` bit j is one. Code 13 does the same for indicator 18+j.
- R4: An invert complements each indicator whose operand bit is one and leaves the others alone. Code 3 uses the storage word, code 7 the accumulator, code 10 the left-half immediate and code 11 the right-half immediate.
- R5: A load replaces all 36 indicators with the operand. Code 1 loads from the storage word and code 5 from the accumulator.
- R6: An OR places a one wherever the operand or the indicator holds a one. Code 2 uses the storage word and code 6 the accumulator.
- R7: A half-word operation (codes 8 to 13) leaves the opposite half of the indicators unchanged.
- R8: Accumulator operand bit k (bit 0 = P) drives indicator k. Indicator k is vector bit k of `ind_q`.
- R9: Code 14 leaves the indicators unchanged. In the following cycle, and for that one cycle only, `acc_wr_valid` is 1, `acc_wr_data[35:0]` holds the indicators and `acc_wr_data[36]` (Q) is 0.
- R10: Code 15 leaves the indicators unchanged. In the following cycle, and for that one cycle only, `stor_wr_valid` is 1 and `stor_wr_data` holds the indicators, with bit 0 = S.
- R11: With `op_valid` low, or with code 0, the indicators do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (0..15) |
| stor_word | input | 36 | Storage operand, bit 0 = S |
| acc_word | input | 36 | Accumulator P..35, bit 0 = P |
| imm | input | 18 | Immediate from instruction bits 18..35 |
| ind_q | output | 36 | Indicator contents, bit k = indicator k |
| acc_wr_valid | output | 1 | Accumulator write strobe |
| acc_wr_data | output | 37 | Accumulator value, bit 36 = Q |
| stor_wr_valid | output | 1 | Storage write strobe |
| stor_wr_data | output | 36 | Storage value, bit 0 = S |

## Verification
The assertions assume that every operand input is a known value whenever `op_valid` is high. They also assume that `op_code` carries one of the sixteen codes listed above, so each accepted cycle matches exactly one operation. The directed tasks keep to this by driving inputs only at the falling edge and by holding `op_valid` high for one cycle per operation. They also set every operand bus to a defined pattern on each operation, including buses the operation ignores. Between operations the operands are changed to unrelated patterns while `op_valid` is low.

// File: rtl/sind_pkg.sv
package sind_pkg;

    // Operation codes; numeric values are part of the block's interface.
    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_LD_STOR  = 4'd1,
        OP_OR_STOR  = 4'd2,
        OP_INV_STOR = 4'd3,
        OP_RST_STOR = 4'd4,
        OP_LD_ACC   = 4'd5,
        OP_OR_ACC   = 4'd6,
        OP_INV_ACC  = 4'd7,
        OP_SET_LH   = 4'd8,
        OP_SET_RH   = 4'd9,
        OP_INV_LH   = 4'd10,
        OP_INV_RH   = 4'd11,
        OP_RST_LH   = 4'd12,
        OP_RST_RH   = 4'd13,
        OP_TO_ACC   = 4'd14,
        OP_TO_STOR  = 4'd15
    } sind_op_e;

    // Operand source selection
    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_STOR,
        SRC_ACC,
        SRC_IMM_LO,
        SRC_IMM_HI
    } sind_src_e;

    // Decoded control bundle
    typedef struct packed {
        logic      set_en;
        logic      rst_en;
        logic      clr_all;
        sind_src_e src;
        logic      to_acc;
        logic      to_stor;
    } sind_ctl_t;

    // Transfer sequencer states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACC_PUSH,
        ST_STOR_PUSH
    } sind_state_e;

endpackage

// File: rtl/sind_ctrl_decode.sv
module sind_ctrl_decode
    import sind_pkg::*;
(
    input  logic      op_valid,
    input  sind_op_e  op,
    output sind_ctl_t ctl
);

    always_comb begin
        ctl = '{set_en: 1'b0, rst_en: 1'b0, clr_all: 1'b0,
                src: SRC_NONE, to_acc: 1'b0, to_stor: 1'b0};
        if (op_valid) begin
            unique case (op)
                OP_NOP: ;
                OP_LD_STOR: begin
                    ctl.clr_all = 1'b1;
                    ctl.set_en  = 1'b1;
                    ctl.src     = SRC_STOR;
                end
                OP_OR_STOR: begin
                    ctl.set_en = 1'b1;
                    ctl.src    = SRC_STOR;
                end
                OP_INV_STOR: begin
                    ctl.set_en = 1'b1;
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_STOR;
                end
                OP_RST_STOR: begin
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_STOR;
                end
                OP_LD_ACC: begin
                    ctl.clr_all = 1'b1;
                    ctl.set_en  = 1'b1;
                    ctl.src     = SRC_ACC;
                end
                OP_OR_ACC: begin
                    ctl.set_en = 1'b1;
                    ctl.src    = SRC_ACC;
                end
                OP_INV_ACC: begin
                    ctl.set_en = 1'b1;
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_ACC;
                end
                OP_SET_LH: begin
                    ctl.set_en = 1'b1;
                    ctl.src    = SRC_IMM_LO;
                end
                OP_SET_RH: begin
                    ctl.set_en = 1'b1;
                    ctl.src    = SRC_IMM_HI;
                end
                OP_INV_LH: begin
                    ctl.set_en = 1'b1;
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_IMM_LO;
                end
                OP_INV_RH: begin
                    ctl.set_en = 1'b1;
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_IMM_HI;
                end
                OP_RST_LH: begin
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_IMM_LO;
                end
                OP_RST_RH: begin
                    ctl.rst_en = 1'b1;
                    ctl.src    = SRC_IMM_HI;
                end
                OP_TO_ACC:  ctl.to_acc  = 1'b1;
                OP_TO_STOR: ctl.to_stor = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sind_operand_mux.sv
module sind_operand_mux
    import sind_pkg::*;
#(
    parameter int W = 36
) (
    input  sind_src_e      src,
    input  logic [W-1:0]   stor_word,
    input  logic [W-1:0]   acc_word,
    input  logic [W/2-1:0] imm,
    output logic [W-1:0]   operand
);

    localparam int HW = W / 2;

    logic [W-1:0] imm_lo_word;
    logic [W-1:0] imm_hi_word;

    // Immediate bit j lands on indicator j (left half) or HW+j (right half);
    // the untouched half carries zeros so no control line fires there.
    for (genvar j = 0; j < HW; j++) begin : g_steer
        assign imm_lo_word[j]      = imm[j];
        assign imm_lo_word[HW + j] = 1'b0;
        assign imm_hi_word[j]      = 1'b0;
        assign imm_hi_word[HW + j] = imm[j];
    end

    always_comb begin
        unique case (src)
            SRC_STOR:   operand = stor_word;
            SRC_ACC:    operand = acc_word;
            SRC_IMM_LO: operand = imm_lo_word;
            SRC_IMM_HI: operand = imm_hi_word;
            default:    operand = '0;
        endcase
    end

endmodule

// File: rtl/sind_bit_cell.sv
module sind_bit_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic set_i,
    input  logic rst_i,
    output logic q
);

    logic base;
    logic nxt;

    // Pre-clear stage, then the two control lines act on the result.
    always_comb begin
        base = clr_i ? 1'b0 : q;
        unique case ({set_i, rst_i})
            2'b11:   nxt = ~base;
            2'b10:   nxt = 1'b1;
            2'b01:   nxt = 1'b0;
            default: nxt = base;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

endmodule

// File: rtl/sind_reg_unit.sv
module sind_reg_unit
    import sind_pkg::*;
#(
    parameter int W = 36
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [3:0]     op_code,
    input  logic [W-1:0]   stor_word,
    input  logic [W-1:0]   acc_word,
    input  logic [W/2-1:0] imm,
    output logic [W-1:0]   ind_q,
    output logic           acc_wr_valid,
    output logic [W:0]     acc_wr_data,
    output logic           stor_wr_valid,
    output logic [W-1:0]   stor_wr_data
);

    localparam int HW = W / 2;

    sind_ctl_t    ctl;
    logic [W-1:0] operand;
    logic [W-1:0] set_line;
    logic [W-1:0] rst_line;
    sind_state_e  state_q;
    sind_state_e  state_d;
    logic [W-1:0] xfer_q;

    sind_ctrl_decode u_dec (
        .op_valid (op_valid),
        .op       (sind_op_e'(op_code)),
        .ctl      (ctl)
    );

    sind_operand_mux #(.W(W)) u_mux (
        .src       (ctl.src),
        .stor_word (stor_word),
        .acc_word  (acc_word),
        .imm       (imm[HW-1:0]),
        .operand   (operand)
    );

    // Per-bit control lines gated by the operand bit
    for (genvar k = 0; k < W; k++) begin : g_bit
        assign set_line[k] = ctl.set_en & operand[k];
        assign rst_line[k] = ctl.rst_en & operand[k];

        sind_bit_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (ctl.clr_all),
            .set_i (set_line[k]),
            .rst_i (rst_line[k]),
            .q     (ind_q[k])
        );
    end

    // Transfer sequencer: next state
    always_comb begin
        if (ctl.to_acc)       state_d = ST_ACC_PUSH;
        else if (ctl.to_stor) state_d = ST_STOR_PUSH;
        else                  state_d = ST_IDLE;
    end

    // State register and transfer capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            xfer_q  <= '0;
        end else begin
            state_q <= state_d;
            if (ctl.to_acc || ctl.to_stor) xfer_q <= ind_q;
        end
    end

    // Outputs by state
    always_comb begin
        acc_wr_valid  = 1'b0;
        stor_wr_valid = 1'b0;
        acc_wr_data   = '0;
        stor_wr_data  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACC_PUSH: begin
                acc_wr_valid     = 1'b1;
                acc_wr_data[W]   = 1'b0;
                acc_wr_data[W-1:0] = xfer_q;
            end
            ST_STOR_PUSH: begin
                stor_wr_valid = 1'b1;
                stor_wr_data  = xfer_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sind_reg_unit_chk.sv
module sind_reg_unit_chk
    import sind_pkg::*;
#(
    parameter int W = 36
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] ind_q,
    input logic         acc_wr_valid,
    input logic [W:0]   acc_wr_data,
    input logic         stor_wr_valid,
    input logic [W-1:0] stor_wr_data
);

    localparam int HW = W / 2;

    logic set_op;
    logic rst_op;
    logic lh_op;
    logic rh_op;
    assign set_op = op_valid && (op_code == OP_SET_LH || op_code == OP_SET_RH);
    assign rst_op = op_valid && (op_code == OP_RST_STOR || op_code == OP_RST_LH ||
                                 op_code == OP_RST_RH);
    assign lh_op  = op_valid && (op_code == OP_SET_LH || op_code == OP_INV_LH ||
                                 op_code == OP_RST_LH);
    assign rh_op  = op_valid && (op_code == OP_SET_RH || op_code == OP_INV_RH ||
                                 op_code == OP_RST_RH);

    // R11
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_code == OP_NOP) |=> $stable(ind_q));

    // R2
    set_never_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_op |=> ((ind_q & $past(ind_q)) == $past(ind_q)));

    // R3
    reset_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_op |=> ((ind_q & ~$past(ind_q)) == '0));

    // R7
    left_keeps_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lh_op |=> $stable(ind_q[W-1:HW]));

    // R7
    right_keeps_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rh_op |=> $stable(ind_q[HW-1:0]));

    // R9
    acc_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TO_ACC) |=>
            (acc_wr_valid && !acc_wr_data[W] && acc_wr_data[W-1:0] == $past(ind_q)
             && $stable(ind_q)));

    // R10
    stor_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_TO_STOR) |=>
            (stor_wr_valid && stor_wr_data == $past(ind_q) && $stable(ind_q)));

    // R9
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_wr_valid, stor_wr_valid}));

    // R10
    stor_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stor_wr_valid && !(op_valid && op_code == OP_TO_STOR)) |=> !stor_wr_valid);

endmodule

bind sind_reg_unit sind_reg_unit_chk #(.W(W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .op_code       (op_code),
    .ind_q         (ind_q),
    .acc_wr_valid  (acc_wr_valid),
    .acc_wr_data   (acc_wr_data),
    .stor_wr_valid (stor_wr_valid),
    .stor_wr_data  (stor_wr_data)
);

// File: tb/sind_reg_unit_tb.sv
module sind_reg_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [35:0] stor_word = '0;
    logic [35:0] acc_word = '0;
    logic [17:0] imm = '0;
    logic [35:0] ind_q;
    logic        acc_wr_valid;
    logic [36:0] acc_wr_data;
    logic        stor_wr_valid;
    logic [35:0] stor_wr_data;

    int total = 0;
    int bad = 0;
    logic [35:0] exp_ind = '0;

    always #5 clk = ~clk;

    sind_reg_unit #(.W(36)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .stor_word(stor_word), .acc_word(acc_word), .imm(imm),
        .ind_q(ind_q), .acc_wr_valid(acc_wr_valid), .acc_wr_data(acc_wr_data),
        .stor_wr_valid(stor_wr_valid), .stor_wr_data(stor_wr_data)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_ind(input string req);
        check(ind_q === exp_ind, req, {28'd0, ind_q}, {28'd0, exp_ind});
    endtask

    // Drive one operation at the falling edge; return at the next falling edge.
    task automatic do_op(input logic [3:0] code, input logic [35:0] sw,
                         input logic [35:0] aw, input logic [17:0] iv);
        op_valid  = 1'b1;
        op_code   = code;
        stor_word = sw;
        acc_word  = aw;
        imm       = iv;
        @(negedge clk);
        op_valid  = 1'b0;
        op_code   = 4'd0;
    endtask

    task automatic t_reset;
        check(ind_q === 36'd0, "R1 ind", {28'd0, ind_q}, 64'd0);
        check(!acc_wr_valid && !stor_wr_valid, "R1 strobes",
              {62'd0, acc_wr_valid, stor_wr_valid}, 64'd0);
    endtask

    task automatic t_load;
        do_op(4'd1, 36'hA5C3_0F1E_7, 36'hF_FFFF_FFFF, 18'h3FFFF);
        exp_ind = 36'hA5C3_0F1E_7;
        check_ind("R5 load storage");
        do_op(4'd5, 36'hF_FFFF_FFFF, 36'h0_0000_0001, 18'h3FFFF);
        exp_ind = 36'h0_0000_0001;
        check_ind("R8 acc P to indicator 0 / R5 load acc");
    endtask

    task automatic t_or;
        do_op(4'd1, 36'h0_FF00_00F0, 36'd0, 18'd0);
        exp_ind = 36'h0_FF00_00F0;
        do_op(4'd2, 36'h3_0F00_000F, 36'hF_FFFF_FFFF, 18'h3FFFF);
        exp_ind = exp_ind | 36'h3_0F00_000F;
        check_ind("R6 OR storage");
        do_op(4'd6, 36'd0, 36'h8_0000_0100, 18'd0);
        exp_ind = exp_ind | 36'h8_0000_0100;
        check_ind("R6 OR acc");
    endtask

    task automatic t_invert;
        do_op(4'd1, 36'h0_FFFF_0000, 36'd0, 18'd0);
        exp_ind = 36'h0_FFFF_0000;
        do_op(4'd3, 36'h0_F0F0_F0F0, 36'hF_FFFF_FFFF, 18'h3FFFF);
        exp_ind = exp_ind ^ 36'h0_F0F0_F0F0;
        check_ind("R4 invert storage");
        do_op(4'd7, 36'hF_FFFF_FFFF, 36'hC_0000_0003, 18'd0);
        exp_ind = exp_ind ^ 36'hC_0000_0003;
        check_ind("R4 invert acc");
        do_op(4'd10, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h2_0001);
        exp_ind = exp_ind ^ {18'd0, 18'h2_0001};
        check_ind("R4 invert left R7");
        do_op(4'd11, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h0_8004);
        exp_ind = exp_ind ^ {18'h0_8004, 18'd0};
        check_ind("R4 invert right R7");
    endtask

    task automatic t_reset_ops;
        do_op(4'd1, 36'hF_FFFF_FFFF, 36'd0, 18'd0);
        exp_ind = 36'hF_FFFF_FFFF;
        do_op(4'd4, 36'h0_0000_FFFF, 36'd0, 18'd0);
        exp_ind = exp_ind & ~36'h0_0000_FFFF;
        check_ind("R3 reset storage");
        do_op(4'd12, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h3_0000);
        exp_ind = exp_ind & ~{18'd0, 18'h3_0000};
        check_ind("R3 reset left R7");
        do_op(4'd13, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h0_0003);
        exp_ind = exp_ind & ~{18'h0_0003, 18'd0};
        check_ind("R3 reset right R7");
    endtask

    task automatic t_set_half;
        do_op(4'd1, 36'h0_0003_C001, 36'd0, 18'd0);
        exp_ind = 36'h0_0003_C001;
        do_op(4'd8, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h0_0102);
        exp_ind = exp_ind | {18'd0, 18'h0_0102};
        check_ind("R2 set left keeps ones R7");
        do_op(4'd9, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h2_0001);
        exp_ind = exp_ind | {18'h2_0001, 18'd0};
        check_ind("R2 set right");
    endtask

    task automatic t_hold;
        do_op(4'd1, 36'h5_5555_AAAA, 36'd0, 18'd0);
        exp_ind = 36'h5_5555_AAAA;
        op_valid  = 1'b0;
        op_code   = 4'd1;
        stor_word = 36'h0;
        acc_word  = 36'hF_FFFF_FFFF;
        imm       = 18'h3FFFF;
        @(negedge clk);
        op_code = 4'd0;
        check_ind("R11 valid low");
        do_op(4'd0, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h3FFFF);
        check_ind("R11 nop code");
    endtask

    task automatic t_transfer;
        do_op(4'd1, 36'h9_8765_4321, 36'd0, 18'd0);
        exp_ind = 36'h9_8765_4321;
        do_op(4'd14, 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 18'h3FFFF);
        check(acc_wr_valid === 1'b1 && acc_wr_data === {1'b0, exp_ind},
              "R9 acc push", {27'd0, acc_wr_valid, acc_wr_data}, {27'd0, 1'b1, 1'b0, exp_ind});
        check_ind("R9 indicators kept");
        @(negedge clk);
        check(acc_wr_valid === 1'b0, "R9 single cycle", {63'd0, acc_wr_valid}, 64'd0);
        do_op(4'd15, 36'h0, 36'h0, 18'h0);
        check(stor_wr_valid === 1'b1 && stor_wr_data === exp_ind && !acc_wr_valid,
              "R10 store push", {28'd0, stor_wr_data}, {28'd0, exp_ind});
        check_ind("R10 indicators kept");
        @(negedge clk);
        check(stor_wr_valid === 1'b0, "R10 single cycle", {63'd0, stor_wr_valid}, 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_or();
        t_invert();
        t_reset_ops();
        t_set_half();
        t_hold();
        t_transfer();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule